// File: doc/BRIEF.md
# Watchdog Timer with Selectable Unit and Shaped Reset Output

This block is a watchdog held in a small bank of configuration registers. Software loads an 8-bit timeout count and enables the timer. The count then falls by one for every elapsed second, or for every elapsed minute when the unit bit is set. A single input pulse once per millisecond is the only timebase, and internal prescalers turn it into seconds and minutes. Writing the timeout count again reloads the counter and restarts the prescalers, so the same write is the keepalive.

When the count reaches zero the block records a sticky timeout flag and, if the output is enabled, drives an active-low reset pin. The pin can hold a steady level until software acts, or it can give one pulse whose width is chosen from a four-entry table of millisecond widths. The flag survives a system reset, which is usually the reset the pin itself causes, so software can tell afterwards that the watchdog fired. Only a power-on reset or a write-one-to-clear removes the flag.

Top module: `wdog_timer`

## Requirements
- R1: A write to address 0xF6 loads the count, clears any expiry, and restarts both prescalers. A read of 0xF6 returns the live count.
- R2: With 0xF5 bit 3 clear (seconds), the count falls by one for every MS_PER_SEC ticks. A load of T expires after T*MS_PER_SEC ticks and not before.
- R3: With 0xF5 bit 3 set (minutes), the count falls by one for every MS_PER_SEC*SEC_PER_MIN ticks. A load of T expires after T*MS_PER_SEC*SEC_PER_MIN ticks.
- R4: The timer runs only while 0xF5 bit 5 and 0x30 bit 0 are both 1. While either is 0, ticks leave the count unchanged, the prescalers clear, and an expiry is withdrawn.
- R5: A count of 0 expires on the clock after the timer runs, without any tick.
- R6: With 0xF5 bit 4 clear (level mode), the pin stays low after expiry until the count is rewritten or the timer stops.
- R7: With 0xF5 bit 4 set (pulse mode), expiry gives one low pulse that lasts PW0, PW1, PW2 or PW3 ticks for width codes 0 to 3 in 0xF5 bits 1:0. It is not repeated.
- R8: 0xF0 bit 7 gates the pin. While it is clear, an expiry sets the flag but the pin stays high. Setting the bit while expired in level mode drives the pin low.
- R9: 0xF5 bit 6 is set on expiry. A write with bit 6 = 1 clears it, and a write with bit 6 = 0 leaves it set. A system reset keeps it, and a power-on reset clears it.
- R10: Reads return data one clock after the address. 0x30 returns bit 0. 0xF0 returns bit 7. 0xF5 returns bits 6, 5, 4, 3 and 1:0, with bits 7 and 2 reading 0. All registers read 0 after a power-on reset. A system reset clears every register except the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_por_i | input | 1 | Synchronous power-on reset, active high; clears all state |
| rst_sys_i | input | 1 | Synchronous system reset, active high; keeps the timeout flag |
| tick_ms_i | input | 1 | One-clock pulse per millisecond |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Registered read data for addr_i |
| wdt_rst_n_o | output | 1 | Active-low reset output |

## Verification
A tick that takes the count to zero lands on one edge. The expiry state sets on the next edge, and the pin changes on the edge after that. The bench therefore waits three clocks after the final tick before sampling the pin, and checks one tick earlier that the pin is still high. A read samples the register on the first edge after the address is driven, and the bench takes it at the following falling edge. Pulse widths are measured by issuing ticks one at a time and sampling two clocks after each, which matches the one-edge decrement plus the one-edge output register.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DW = 8;

  localparam logic [7:0] ADDR_LDEN = 8'h30;
  localparam logic [7:0] ADDR_OEN  = 8'hF0;
  localparam logic [7:0] ADDR_CONF = 8'hF5;
  localparam logic [7:0] ADDR_TIME = 8'hF6;

  localparam int BIT_LDEN  = 0;
  localparam int BIT_OEN   = 7;
  localparam int BIT_FLAG  = 6;
  localparam int BIT_RUN   = 5;
  localparam int BIT_PULSE = 4;
  localparam int BIT_UNIT  = 3;

  typedef struct packed {
    logic       run_en;
    logic       pulse_mode;
    logic       unit_min;
    logic [1:0] width_code;
  } wdog_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_por,
  input  logic          rst_sys,
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          fire,
  input  logic [CW-1:0] live_cnt,
  output logic [DW-1:0] rdata,
  output wdog_cfg_t     cfg,
  output logic          ld_en,
  output logic          out_en,
  output logic          time_wr
);
  logic flag_q;
  logic conf_wr;
  logic [DW-1:0] rd_mux;

  assign time_wr = wr_en && (addr == ADDR_TIME);
  assign conf_wr = wr_en && (addr == ADDR_CONF);

  always_ff @(posedge clk) begin
    if (rst_por || rst_sys) begin
      cfg    <= '0;
      ld_en  <= 1'b0;
      out_en <= 1'b0;
    end else if (wr_en) begin
      if (addr == ADDR_LDEN) ld_en  <= wdata[BIT_LDEN];
      if (addr == ADDR_OEN)  out_en <= wdata[BIT_OEN];
      if (conf_wr) begin
        cfg.run_en     <= wdata[BIT_RUN];
        cfg.pulse_mode <= wdata[BIT_PULSE];
        cfg.unit_min   <= wdata[BIT_UNIT];
        cfg.width_code <= wdata[1:0];
      end
    end
  end

  // Sticky flag: only power-on reset or write-one clears it
  always_ff @(posedge clk) begin
    if (rst_por)                          flag_q <= 1'b0;
    else if (fire)                        flag_q <= 1'b1;
    else if (conf_wr && wdata[BIT_FLAG])  flag_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADDR_LDEN: rd_mux[BIT_LDEN] = ld_en;
      ADDR_OEN:  rd_mux[BIT_OEN]  = out_en;
      ADDR_CONF: begin
        rd_mux[BIT_FLAG]  = flag_q;
        rd_mux[BIT_RUN]   = cfg.run_en;
        rd_mux[BIT_PULSE] = cfg.pulse_mode;
        rd_mux[BIT_UNIT]  = cfg.unit_min;
        rd_mux[1:0]       = cfg.width_code;
      end
      ADDR_TIME: rd_mux = DW'(live_cnt);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_por || rst_sys) rdata <= '0;
    else                    rdata <= rd_mux;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst_por)
    flag_q && !(conf_wr && wdata[BIT_FLAG]) |=> flag_q); // R9
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst_por)
    fire |=> flag_q); // R9
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int MS_PER_SEC  = 1000,
  parameter int SEC_PER_MIN = 60,
  parameter int CW          = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          unit_min,
  input  logic          tick,
  input  logic          time_wr,
  input  logic [CW-1:0] time_val,
  output logic [CW-1:0] cnt_o,
  output logic          expired_o,
  output logic          fire_o
);
  localparam int MSW = $clog2(MS_PER_SEC + 1);
  localparam int SMW = $clog2(SEC_PER_MIN + 1);

  logic [MSW-1:0] ms_q;
  logic [SMW-1:0] sec_q;
  logic [CW-1:0]  cnt_q;
  logic           expired_q;
  logic           sec_tick, min_tick, unit_tick;

  assign sec_tick  = tick && (ms_q == MSW'(MS_PER_SEC - 1));
  assign min_tick  = sec_tick && (sec_q == SMW'(SEC_PER_MIN - 1));
  assign unit_tick = unit_min ? min_tick : sec_tick;
  assign fire_o    = run && !time_wr && !expired_q && (cnt_q == '0);
  assign cnt_o     = cnt_q;
  assign expired_o = expired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ms_q      <= '0;
      sec_q     <= '0;
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (time_wr) begin
      cnt_q     <= time_val;
      ms_q      <= '0;
      sec_q     <= '0;
      expired_q <= 1'b0;
    end else if (!run) begin
      ms_q      <= '0;
      sec_q     <= '0;
      expired_q <= 1'b0;
    end else if (!expired_q) begin
      if (cnt_q == '0) begin
        expired_q <= 1'b1;
      end else if (tick) begin
        ms_q <= sec_tick ? '0 : ms_q + 1'b1;
        if (sec_tick) sec_q <= min_tick ? '0 : sec_q + 1'b1;
        if (unit_tick) cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    time_wr |=> (cnt_q == $past(time_val)) && !expired_q); // R1
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run && !time_wr |=> $stable(cnt_q) && !expired_q); // R4
  AST_ZERO_EXPIRES: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> expired_o); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !time_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1)); // R2
endmodule

// File: rtl/wdog_shaper.sv
module wdog_shaper #(
  parameter int PW0 = 1,
  parameter int PW1 = 25,
  parameter int PW2 = 125,
  parameter int PW3 = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fire,
  input  logic       tick,
  input  logic       pulse_mode,
  input  logic [1:0] width_code,
  input  logic       expired,
  input  logic       out_en,
  output logic       rst_n_o
);
  localparam int PW_MAX01 = (PW0 > PW1) ? PW0 : PW1;
  localparam int PW_MAX23 = (PW2 > PW3) ? PW2 : PW3;
  localparam int PW_MAX   = (PW_MAX01 > PW_MAX23) ? PW_MAX01 : PW_MAX23;
  localparam int PWW      = $clog2(PW_MAX + 1);

  logic [PWW-1:0] pulse_q;
  logic [PWW-1:0] width_sel;
  logic           drive;

  always_comb begin
    case (width_code)
      2'd0:    width_sel = PWW'(PW0);
      2'd1:    width_sel = PWW'(PW1);
      2'd2:    width_sel = PWW'(PW2);
      default: width_sel = PWW'(PW3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                          pulse_q <= '0;
    else if (fire)                    pulse_q <= width_sel;
    else if (tick && pulse_q != '0)   pulse_q <= pulse_q - 1'b1;
  end

  assign drive = out_en && (pulse_mode ? (pulse_q != '0) : expired);

  always_ff @(posedge clk) begin
    if (rst) rst_n_o <= 1'b1;
    else     rst_n_o <= !drive;
  end

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> rst_n_o); // R8
  AST_PULSE_LOAD: assert property (@(posedge clk) disable iff (rst)
    fire |=> pulse_q != '0); // R7
  AST_PULSE_DRAIN: assert property (@(posedge clk) disable iff (rst)
    !fire && !tick |=> $stable(pulse_q)); // R7
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int MS_PER_SEC  = 1000,
  parameter int SEC_PER_MIN = 60,
  parameter int PW0         = 1,
  parameter int PW1         = 25,
  parameter int PW2         = 125,
  parameter int PW3         = 5000
) (
  input  logic       clk_i,
  input  logic       rst_por_i,
  input  logic       rst_sys_i,
  input  logic       tick_ms_i,
  input  logic       wr_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       wdt_rst_n_o
);
  localparam int CW = DW;

  wdog_cfg_t     cfg;
  logic          ld_en, out_en, time_wr, fire, expired, rst_any, run;
  logic [CW-1:0] live_cnt;

  assign rst_any = rst_por_i || rst_sys_i;
  assign run     = cfg.run_en && ld_en;

  wdog_regs #(.CW(CW)) regs_i (
    .clk(clk_i), .rst_por(rst_por_i), .rst_sys(rst_sys_i),
    .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
    .fire(fire), .live_cnt(live_cnt), .rdata(rdata_o),
    .cfg(cfg), .ld_en(ld_en), .out_en(out_en), .time_wr(time_wr)
  );

  wdog_countdown #(.MS_PER_SEC(MS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN), .CW(CW)) cnt_i (
    .clk(clk_i), .rst(rst_any), .run(run), .unit_min(cfg.unit_min),
    .tick(tick_ms_i), .time_wr(time_wr), .time_val(wdata_i[CW-1:0]),
    .cnt_o(live_cnt), .expired_o(expired), .fire_o(fire)
  );

  wdog_shaper #(.PW0(PW0), .PW1(PW1), .PW2(PW2), .PW3(PW3)) shp_i (
    .clk(clk_i), .rst(rst_any), .fire(fire), .tick(tick_ms_i),
    .pulse_mode(cfg.pulse_mode), .width_code(cfg.width_code),
    .expired(expired), .out_en(out_en), .rst_n_o(wdt_rst_n_o)
  );
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MSPS = 4;
  localparam int SPM  = 3;
  localparam int PWT[4] = '{1, 2, 3, 5};

  logic clk = 1'b0, por = 1'b1, sys = 1'b0, tick = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic rst_n;
  int n_chk = 0, n_fail = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.MS_PER_SEC(MSPS), .SEC_PER_MIN(SPM),
               .PW0(PWT[0]), .PW1(PWT[1]), .PW2(PWT[2]), .PW3(PWT[3])) dut_i (
    .clk_i(clk), .rst_por_i(por), .rst_sys_i(sys), .tick_ms_i(tick),
    .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .wdt_rst_n_o(rst_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic arm(input int unit, input int pmode, input int code, input int t);
    wr(8'hF5, 8'h40);
    wr(8'hF6, 8'(t));
    wr(8'hF5, 8'(8'h20 | (unit << 3) | (pmode << 4) | code));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3); por = 1'b0; idle(1);
    // R10 reset state
    rd(8'h30, rv); chk("R10 ld reset", rv, 0);
    rd(8'hF0, rv); chk("R10 oen reset", rv, 0);
    rd(8'hF5, rv); chk("R10 conf reset", rv, 0);
    rd(8'hF6, rv); chk("R10 time reset", rv, 0);
    chk("R10 pin reset", rst_n, 1);

    wr(8'h30, 8'hFF); wr(8'hF0, 8'hFF);
    rd(8'h30, rv); chk("R10 ld read", rv, 8'h01);
    rd(8'hF0, rv); chk("R10 oen read", rv, 8'h80);
    wr(8'hF6, 8'd200); wr(8'hF5, 8'hFF);
    rd(8'hF5, rv); chk("R10 conf read", rv, 8'h3B);
    wr(8'hF5, 8'h00);

    // R1 / R4 / R2 count behaviour
    wr(8'hF6, 8'd9);
    rd(8'hF6, rv); chk("R1 load", rv, 9);
    tick_n(20); rd(8'hF6, rv); chk("R4 conf off holds", rv, 9);
    wr(8'hF5, 8'h20); wr(8'h30, 8'h00);
    tick_n(20); rd(8'hF6, rv); chk("R4 ld off holds", rv, 9);
    wr(8'h30, 8'h01);
    tick_n(MSPS); rd(8'hF6, rv); chk("R2 one second", rv, 8);
    tick_n(MSPS - 1); rd(8'hF6, rv); chk("R2 partial second", rv, 8);
    tick_n(1); rd(8'hF6, rv); chk("R2 second step", rv, 7);
    tick_n(MSPS - 1); wr(8'hF6, 8'd9); tick_n(1);
    rd(8'hF6, rv); chk("R1 prescaler restart", rv, 9);

    // R2 seconds sweep
    for (int t = 1; t <= 4; t++) begin
      arm(0, 0, 0, t);
      tick_n(t * MSPS - 1); idle(3); chk("R2 not yet", rst_n, 1);
      tick_n(1); idle(3); chk("R2 expiry", rst_n, 0);
      rd(8'hF5, rv); chk("R9 flag set", rv[6], 1);
    end
    // R3 minutes sweep
    for (int t = 1; t <= 2; t++) begin
      arm(1, 0, 0, t);
      tick_n(t * MSPS * SPM - 1); idle(3); chk("R3 not yet", rst_n, 1);
      tick_n(1); idle(3); chk("R3 expiry", rst_n, 0);
    end

    // R6 level hold and release
    tick_n(10); idle(2); chk("R6 level holds", rst_n, 0);
    wr(8'hF6, 8'd3); idle(2); chk("R6 rewrite releases", rst_n, 1);
    arm(0, 0, 0, 2); tick_n(2 * MSPS); idle(3); chk("R6 expired again", rst_n, 0);
    wr(8'hF5, 8'h40); idle(2); chk("R6 disable releases", rst_n, 1);
    rd(8'hF5, rv); chk("R9 w1c clears", rv, 0);

    // R5 zero count
    wr(8'hF6, 8'd0); wr(8'hF5, 8'h20); idle(3);
    chk("R5 zero expires", rst_n, 0);
    rd(8'hF5, rv); chk("R5 flag on zero", rv[6], 1);

    // R7 pulse widths
    for (int c = 0; c < 4; c++) begin
      int k;
      arm(0, 1, c, 1);
      tick_n(MSPS); idle(3); chk("R7 pulse starts", rst_n, 0);
      k = 0;
      while (rst_n == 1'b0 && k < 20) begin
        tick_n(1); idle(2); k++;
      end
      chk("R7 pulse width", k, PWT[c]);
      tick_n(4); idle(2); chk("R7 no repeat", rst_n, 1);
    end

    // R8 output enable
    wr(8'hF0, 8'h00);
    arm(0, 0, 0, 1); tick_n(MSPS); idle(3);
    chk("R8 pin gated", rst_n, 1);
    rd(8'hF5, rv); chk("R8 flag still set", rv[6], 1);
    wr(8'hF0, 8'h80); idle(2); chk("R8 enable drives", rst_n, 0);

    // R9 write-zero keeps, system reset keeps, power-on clears
    wr(8'hF5, 8'h20);
    rd(8'hF5, rv); chk("R9 write zero keeps", rv[6], 1);
    @(negedge clk); sys = 1'b1; idle(2); sys = 1'b0;
    rd(8'hF5, rv); chk("R9 sys reset keeps flag", rv, 8'h40);
    rd(8'h30, rv); chk("R10 sys reset clears ld", rv, 0);
    chk("R9 pin after sys reset", rst_n, 1);
    @(negedge clk); por = 1'b1; idle(2); por = 1'b0;
    rd(8'hF5, rv); chk("R9 por clears flag", rv, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule